// File: doc/BRIEF.md
# Twos-Complement Adder-Subtracter with Status Flags

This block is a purely combinational arithmetic unit for signed and unsigned twos-complement words. A 2-bit function select picks one of three results: the sum of the two operands, the first operand minus the second, or the second operand minus the first. Alongside the result it reports the carry out of the most significant bit, a signed overflow flag and a zero flag.

The word is built from 4-bit ripple-carry slices chained carry-out to carry-in, so the width may be 4, 8 or 16 bits (any multiple of four). Gate count is kept low rather than delay. Each subtraction is done by inverting the subtrahend and forcing a carry-in of one. Overflow is taken from the two carries on either side of the sign bit, and the ripple chain exposes both of them directly. There is no state: results follow the inputs after the ripple delay, and the block is meant to sit inside a registered datapath stage.

Top module: `addsub_flags`

## Requirements
- R1: With select 2'b00 the result is (x + y) modulo 2^WIDTH.
- R2: With select 2'b01 the result is (x - y) modulo 2^WIDTH.
- R3: With select 2'b10 the result is (y - x) modulo 2^WIDTH.
- R4: Select 2'b11 behaves exactly like 2'b00 in the result and in all three flags.
- R5: The carry flag is the unmodified carry out of bit WIDTH-1. In the add modes it is 1 when the unsigned sum exceeds 2^WIDTH-1. With select 2'b01 it is 1 when x >= y as unsigned numbers, and with select 2'b10 it is 1 when y >= x (1 means no borrow).
- R6: The overflow flag is the XOR of the carry into bit WIDTH-1 and the carry out of bit WIDTH-1. It is 1 exactly when the true signed result lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. This includes negating the most negative value.
- R7: The zero flag is 1 exactly when every result bit is 0, whatever the carry and overflow are.
- R8: At WIDTH 16 the four slices pass carries across slice boundaries, so a carry that rises in the lowest slice reaches the top bit and the carry flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_x | input | WIDTH | First operand |
| opnd_y | input | WIDTH | Second operand |
| func_sel | input | 2 | 00 add, 01 x minus y, 10 y minus x, 11 add |
| result | output | WIDTH | Arithmetic result, low WIDTH bits |
| carry_out | output | 1 | Carry out of the sign bit |
| overflow | output | 1 | Signed overflow |
| zero | output | 1 | All result bits are zero |

## Verification
The zero flag and the overflow flag can both be set by the same operation. Adding the most negative value to itself wraps to zero with overflow and carry set, and subtracting the most negative value from itself gives zero with no overflow. At 4 bits the bench applies every operand pair under every select value, so all such coincidences occur. Each one is judged against signed integer arithmetic computed in the bench. At 16 bits, directed operands that ripple a carry through all slices check that wide words land on the same flag combinations.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    // Width of one ripple-carry building slice
    localparam int SLICE_W = 4;

    // Function select encoding
    typedef enum logic [1:0] {
        FN_ADD     = 2'b00,
        FN_SUB_XY  = 2'b01,
        FN_SUB_YX  = 2'b10,
        FN_ADD_ALT = 2'b11
    } fn_sel_e;

endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_x,
    input  logic [WIDTH-1:0] opnd_y,
    input  logic [1:0]       func_sel,
    output logic [WIDTH-1:0] add_a,
    output logic [WIDTH-1:0] add_b,
    output logic             carry_seed
);

    fn_sel_e fn;
    assign fn = fn_sel_e'(func_sel);

    // Subtrahend is inverted and the chain is seeded with one
    always_comb begin
        unique case (fn)
            FN_SUB_XY: begin
                add_a      = opnd_x;
                add_b      = ~opnd_y;
                carry_seed = 1'b1;
            end
            FN_SUB_YX: begin
                add_a      = ~opnd_x;
                add_b      = opnd_y;
                carry_seed = 1'b1;
            end
            default: begin
                add_a      = opnd_x;
                add_b      = opnd_y;
                carry_seed = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/addsub_slice4.sv
module addsub_slice4
    import addsub_pkg::*;
(
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  logic               c_in,
    output logic [SLICE_W-1:0] s,
    output logic               c_top_in,
    output logic               c_out
);

    // Ripple through full adders, bit 0 first
    always_comb begin
        logic c;
        c        = c_in;
        c_top_in = 1'b0;
        s        = '0;
        for (int i = 0; i < SLICE_W; i++) begin
            if (i == SLICE_W - 1) begin
                c_top_in = c;
            end
            s[i] = a[i] ^ b[i] ^ c;
            c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        c_out = c;
    end

endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] sum,
    input  logic             c_into_sign,
    input  logic             c_from_sign,
    output logic             ovf,
    output logic             is_zero
);

    assign ovf     = c_into_sign ^ c_from_sign;
    assign is_zero = ~|sum;

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_x,
    input  logic [WIDTH-1:0] opnd_y,
    input  logic [1:0]       func_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow,
    output logic             zero
);

    localparam int N_SLICE = WIDTH / SLICE_W;

    if ((WIDTH % SLICE_W) != 0 || WIDTH < SLICE_W) begin : g_bad_width
        $error("addsub_flags: WIDTH must be a positive multiple of 4");
    end

    logic [WIDTH-1:0] add_a;
    logic [WIDTH-1:0] add_b;
    logic             carry_seed;
    logic [WIDTH-1:0] sum;
    logic             c_sign_in;
    logic             c_sign_out;

    addsub_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .opnd_x     (opnd_x),
        .opnd_y     (opnd_y),
        .func_sel   (func_sel),
        .add_a      (add_a),
        .add_b      (add_b),
        .carry_seed (carry_seed)
    );

    for (genvar k = 0; k < N_SLICE; k++) begin : g_slice
        logic               cin_k;
        logic               cmsb_k;
        logic               cout_k;
        logic [SLICE_W-1:0] s_k;

        if (k == 0) begin : g_first
            assign cin_k = carry_seed;
        end else begin : g_next
            assign cin_k = g_slice[k-1].cout_k;
        end

        addsub_slice4 u_slice (
            .a        (add_a[k*SLICE_W +: SLICE_W]),
            .b        (add_b[k*SLICE_W +: SLICE_W]),
            .c_in     (cin_k),
            .s        (s_k),
            .c_top_in (cmsb_k),
            .c_out    (cout_k)
        );

        assign sum[k*SLICE_W +: SLICE_W] = s_k;
    end

    assign c_sign_in  = g_slice[N_SLICE-1].cmsb_k;
    assign c_sign_out = g_slice[N_SLICE-1].cout_k;

    addsub_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .sum         (sum),
        .c_into_sign (c_sign_in),
        .c_from_sign (c_sign_out),
        .ovf         (overflow),
        .is_zero     (zero)
    );

    assign result    = sum;
    assign carry_out = c_sign_out;

    // Arithmetic models, independent of the slice chain
    logic [WIDTH:0] chk_u;
    logic [WIDTH:0] chk_s;
    logic           chk_carry;
    fn_sel_e        chk_fn;

    always_comb begin
        chk_fn = fn_sel_e'(func_sel);
        unique case (chk_fn)
            FN_SUB_XY: begin
                chk_u     = {1'b0, opnd_x} - {1'b0, opnd_y};
                chk_s     = {opnd_x[WIDTH-1], opnd_x} - {opnd_y[WIDTH-1], opnd_y};
                chk_carry = ~chk_u[WIDTH];
            end
            FN_SUB_YX: begin
                chk_u     = {1'b0, opnd_y} - {1'b0, opnd_x};
                chk_s     = {opnd_y[WIDTH-1], opnd_y} - {opnd_x[WIDTH-1], opnd_x};
                chk_carry = ~chk_u[WIDTH];
            end
            default: begin
                chk_u     = {1'b0, opnd_x} + {1'b0, opnd_y};
                chk_s     = {opnd_x[WIDTH-1], opnd_x} + {opnd_y[WIDTH-1], opnd_y};
                chk_carry = chk_u[WIDTH];
            end
        endcase
    end

    always_comb begin
        if (chk_fn == FN_ADD || chk_fn == FN_ADD_ALT) begin
            // R1 R4
            add_result_chk: assert (result == chk_s[WIDTH-1:0])
                else $error("add result mismatch");
        end
        if (chk_fn == FN_SUB_XY) begin
            // R2
            sub_xy_result_chk: assert (result == chk_s[WIDTH-1:0])
                else $error("x-y result mismatch");
        end
        if (chk_fn == FN_SUB_YX) begin
            // R3
            sub_yx_result_chk: assert (result == chk_s[WIDTH-1:0])
                else $error("y-x result mismatch");
        end
        // R5
        carry_flag_chk: assert (carry_out == chk_carry)
            else $error("carry flag mismatch");
        // R6
        overflow_flag_chk: assert (overflow == (chk_s[WIDTH] ^ chk_s[WIDTH-1]))
            else $error("overflow flag mismatch");
        // R7
        zero_flag_chk: assert (zero == (chk_s[WIDTH-1:0] == '0))
            else $error("zero flag mismatch");
    end

endmodule

// File: tb/addsub_flags_tb.sv
module addsub_flags_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;

    logic [3:0]  x4, y4, r4;
    logic [1:0]  sel4;
    logic        c4, v4, z4;
    logic [15:0] x16, y16, r16;
    logic [1:0]  sel16;
    logic        c16, v16, z16;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    addsub_flags #(.WIDTH(4)) u_dut (
        .opnd_x(x4), .opnd_y(y4), .func_sel(sel4),
        .result(r4), .carry_out(c4), .overflow(v4), .zero(z4)
    );

    addsub_flags #(.WIDTH(16)) u_dut16 (
        .opnd_x(x16), .opnd_y(y16), .func_sel(sel16),
        .result(r16), .carry_out(c16), .overflow(v16), .zero(z16)
    );

    function automatic void model(input int w, input int ux, input int uy, input int sel,
                                  output int res, output bit cy, output bit ov, output bit zr);
        int modv;
        int half;
        int sx;
        int sy;
        int full;
        modv = 1 << w;
        half = modv / 2;
        sx = (ux >= half) ? ux - modv : ux;
        sy = (uy >= half) ? uy - modv : uy;
        case (sel)
            1: begin full = sx - sy; cy = (ux >= uy); end
            2: begin full = sy - sx; cy = (uy >= ux); end
            default: begin full = sx + sy; cy = ((ux + uy) >= modv); end
        endcase
        ov  = (full >= half) || (full < -half);
        res = ((full % modv) + modv) % modv;
        zr  = (res == 0);
    endfunction

    task automatic apply_check(input string tag, input int w, input int ux, input int uy,
                               input int sel);
        int  e_res;
        bit  e_cy;
        bit  e_ov;
        bit  e_zr;
        int  a_res;
        bit  a_cy;
        bit  a_ov;
        bit  a_zr;
        @(negedge clk);
        if (w == 4) begin
            x4 = 4'(ux); y4 = 4'(uy); sel4 = 2'(sel);
        end else begin
            x16 = 16'(ux); y16 = 16'(uy); sel16 = 2'(sel);
        end
        @(posedge clk);
        #5;
        if (w == 4) begin
            a_res = int'(r4); a_cy = c4; a_ov = v4; a_zr = z4;
        end else begin
            a_res = int'(r16); a_cy = c16; a_ov = v16; a_zr = z16;
        end
        model(w, ux, uy, sel, e_res, e_cy, e_ov, e_zr);
        n_tests++;
        if (a_res != e_res || a_cy != e_cy || a_ov != e_ov || a_zr != e_zr) begin
            n_fail++;
            $display("FAIL %s w=%0d x=%0h y=%0h sel=%0d: got r=%0h c=%0b v=%0b z=%0b, expected r=%0h c=%0b v=%0b z=%0b",
                     tag, w, ux, uy, sel, a_res, a_cy, a_ov, a_zr, e_res, e_cy, e_ov, e_zr);
        end
    endtask

    // Quiet inputs give zero result with only the zero flag set (R7)
    task automatic t_idle();
        apply_check("R7 idle", 4, 0, 0, 0);
        apply_check("R7 idle", 16, 0, 0, 0);
    endtask

    // Every 4-bit pair added: R1 result, R5 carry, R6 overflow, R7 zero
    task automatic t_add_all();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                apply_check("R1 R5 R6 R7 add", 4, a, b, 0);
    endtask

    // Every 4-bit pair, x minus y: R2 with borrow (R5) and overflow (R6)
    task automatic t_sub_all();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                apply_check("R2 R5 R6 R7 x-y", 4, a, b, 1);
    endtask

    // Every 4-bit pair, y minus x: R3, including negating -8 (R6)
    task automatic t_rsub_all();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                apply_check("R3 R5 R6 R7 y-x", 4, a, b, 2);
    endtask

    // Select 11 matches plain add on every pair (R4)
    task automatic t_alias_sel();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                apply_check("R4 sel11", 4, a, b, 3);
    endtask

    // Most negative cases where zero and overflow coincide (R6 R7)
    task automatic t_min_corner();
        apply_check("R6 R7 -8+-8", 4, 8, 8, 0);
        apply_check("R6 R7 -8-(-8)", 4, 8, 8, 1);
        apply_check("R6 0-(-8)", 4, 8, 0, 2);
        apply_check("R6 R7 min16", 16, 16'h8000, 16'h8000, 0);
    endtask

    // Carries that cross slice boundaries at 16 bits (R8)
    task automatic t_wide();
        apply_check("R8 slice carry", 16, 16'h000F, 16'h0001, 0);
        apply_check("R8 full ripple", 16, 16'hFFFF, 16'h0001, 0);
        apply_check("R8 to sign", 16, 16'h7FFF, 16'h0001, 0);
        apply_check("R8 borrow", 16, 16'h8000, 16'h0001, 1);
        apply_check("R8 neg min", 16, 16'h8000, 16'h0000, 2);
        apply_check("R8 big sub", 16, 16'h1234, 16'hFEDC, 1);
        apply_check("R8 big rsub", 16, 16'h1234, 16'hFEDC, 2);
        apply_check("R8 sel11", 16, 16'hA5A5, 16'h5A5B, 3);
        apply_check("R8 equal", 16, 16'h4321, 16'h4321, 1);
    endtask

    initial begin
        x4 = '0; y4 = '0; sel4 = '0;
        x16 = '0; y16 = '0; sel16 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_add_all();
        t_sub_all();
        t_rsub_all();
        t_alias_sel();
        t_min_corner();
        t_wide();
        finished = 1'b1;
    end

    initial begin
        fork
            begin
                wait (finished);
            end
            begin
                repeat (200000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule